// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external bus cycles of a processor with an 8-bit data bus, a 20-bit address space and a multiplexed address/data bus. A core-side requester asks for a code fetch, memory read, memory write, I/O read or I/O write. Each request carries a 20-bit address and, for writes, a data byte. The block runs each request as a bus cycle of four clocks, T1 to T4. When the addressed device holds ready low, it stretches the cycle with wait clocks (Tw). When no request is waiting, it leaves the bus in idle clocks (Ti).

The address is split across two kinds of pin. The top nibble and the low byte share pins with status and data, so they appear only in T1, and an external latch captures them on the falling edge of the address latch enable. The middle byte has pins of its own and holds for the whole cycle. The three-bit status of the next cycle is shown during the clock before its T1, which is the T4 of the current cycle or an idle clock. External logic decodes this status into read and write strobes. A request is taken with a valid/ready handshake. A done strobe marks the last clock of the cycle and carries the read byte with it.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle. `stat_n` is 3'b111 (passive), `ale`, `ad_oe` and `done` are low, and `req_ready` is high.
- R2: With `rdy` high, a bus cycle is exactly four clocks, from the clock in which `ale` is high to the clock in which `done` is high. `done` is high for one clock only, in T4.
- R3: `ale` is high only during T1. During T1, `ad_oe` is high, `ad_out` carries address bits 7:0 and `addr_hi` carries address bits 19:16.
- R4: `addr_mid` carries address bits 15:8 and stays unchanged from T1 through T4.
- R5: The status code follows `req_kind` as follows: 0 fetch gives 3'b100, 1 memory read gives 3'b101, 2 memory write gives 3'b110, 3 I/O read gives 3'b001, 4 I/O write gives 3'b010.
- R6: The status of a cycle is shown in the clock just before its T1 and held through T1 and T2. It is 3'b111 in T3, in Tw, and in any idle clock or T4 with no request pending.
- R7: `rdy` is sampled at the end of T3 and at the end of each Tw. Each sample found low adds one Tw clock, so a cycle with n low samples lasts 4+n clocks.
- R8: For a write, `ad_oe` stays high from T2 through T4 and `ad_out` carries the write byte.
- R9: For a read, `ad_oe` is low from T2 onward. `rd_data` holds the `ad_in` value sampled at the clock edge where `rdy` is found high, and it is valid while `done` is high.
- R10: `req_ready` is high in idle clocks and in T4. A request present with `req_ready` high starts T1 on the next clock, so back-to-back requests run with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request is taken at the next edge when valid |
| rd_data | output | 8 | Read byte, valid with done |
| done | output | 1 | Last clock (T4) of a bus cycle |
| ad_out | output | 8 | Multiplexed address low byte / data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 8 | Multiplexed pins as seen from the bus |
| addr_hi | output | 4 | Address bits 19:16 in T1, zero otherwise |
| addr_mid | output | 8 | Address bits 15:8, dedicated pins |
| ale | output | 1 | Address latch enable, high in T1 |
| stat_n | output | 3 | Bus status code, 3'b111 passive |
| rdy | input | 1 | Device ready |

## Verification
On every clock, the assertions check the per-cycle rules: `ale` is a single-clock pulse, the middle address byte stays stable, status goes passive in T3 and Tw and holds into T1, a low `rdy` forces a wait clock, the pins float during reads, and `done` appears only in T4 after `rdy` is found high. Some behaviour only the bench scenarios can show. These are the full address seen in T1, the exact length of a cycle under a chosen number of waits, the status code of each request kind, the read byte returned from the device model, the write byte on the pins, and back-to-back requests running with no idle clock between them.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [19:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_ready,
  output logic [7:0]  rd_data,
  output logic        done,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [3:0]  addr_hi,
  output logic [7:0]  addr_mid,
  output logic        ale,
  output logic [2:0]  stat_n,
  input  logic        rdy
);
  typedef enum logic [2:0] {
    S_TI = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_T3 = 3'd3, S_TW = 3'd4, S_T4 = 3'd5
  } phase_t;

  localparam logic [2:0] PASSIVE = 3'b111;

  phase_t      state, state_nx;
  logic [2:0]  cur_kind;
  logic [19:0] cur_addr;
  logic [7:0]  cur_wdata;

  function automatic logic [2:0] code_of(input logic [2:0] k);
    case (k)
      3'd0:    code_of = 3'b100;
      3'd1:    code_of = 3'b101;
      3'd2:    code_of = 3'b110;
      3'd3:    code_of = 3'b001;
      3'd4:    code_of = 3'b010;
      default: code_of = PASSIVE;
    endcase
  endfunction

  wire cur_wr    = (cur_kind == 3'd2) || (cur_kind == 3'd4);
  wire take      = req_valid && req_ready;
  wire last_samp = (state == S_T3 || state == S_TW) && rdy;
  wire data_ph   = (state == S_T2) || (state == S_T3) || (state == S_TW) || (state == S_T4);

  assign req_ready = (state == S_TI) || (state == S_T4);
  assign ale       = (state == S_T1);
  assign addr_mid  = cur_addr[15:8];
  assign addr_hi   = ale ? cur_addr[19:16] : 4'h0;
  assign ad_oe     = ale || (data_ph && cur_wr);
  assign ad_out    = ale ? cur_addr[7:0] : (ad_oe ? cur_wdata : 8'h00);

  always_comb begin
    case (state)
      S_TI, S_T4: stat_n = req_valid ? code_of(req_kind) : PASSIVE;
      S_T1, S_T2: stat_n = code_of(cur_kind);
      default:    stat_n = PASSIVE;
    endcase
  end

  always_comb begin
    case (state)
      S_TI:    state_nx = req_valid ? S_T1 : S_TI;
      S_T1:    state_nx = S_T2;
      S_T2:    state_nx = S_T3;
      S_T3:    state_nx = rdy ? S_T4 : S_TW;
      S_TW:    state_nx = rdy ? S_T4 : S_TW;
      S_T4:    state_nx = req_valid ? S_T1 : S_TI;
      default: state_nx = S_TI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_TI;
      cur_kind  <= 3'd0;
      cur_addr  <= 20'h0;
      cur_wdata <= 8'h00;
      done      <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      state <= state_nx;
      done  <= last_samp;
      if (take) begin
        cur_kind  <= req_kind;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
      if (last_samp && !cur_wr) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic [2:0] cur_kind,
  input logic       ale,
  input logic [7:0] addr_mid,
  input logic [2:0] stat_n,
  input logic       ad_oe,
  input logic       done,
  input logic       rdy
);
  wire in_wait = (state == 3'd3) || (state == 3'd4);
  wire is_wr   = (cur_kind == 3'd2) || (cur_kind == 3'd4);
  wire after1  = (state == 3'd2) || in_wait || (state == 3'd5);

  AST_ALE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);                          // R3
  AST_MID_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) after1 |-> $stable(addr_mid));          // R4
  AST_STAT_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n) in_wait |-> stat_n == 3'b111);          // R6
  AST_STAT_CARRY:   assert property (@(posedge clk) disable iff (!rst_n) ale |-> stat_n == $past(stat_n));       // R6
  AST_WAIT_INSERT:  assert property (@(posedge clk) disable iff (!rst_n) (in_wait && !rdy) |=> (in_wait && !done)); // R7
  AST_READ_FLOAT:   assert property (@(posedge clk) disable iff (!rst_n) (after1 && !is_wr) |-> !ad_oe);          // R9
  AST_WRITE_DRIVE:  assert property (@(posedge clk) disable iff (!rst_n) (after1 && is_wr) |-> ad_oe);           // R8
  AST_DONE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n) (in_wait && rdy) |=> done);           // R2
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                        // R2
endmodule

bind bus_cycle_seq bus_cycle_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .cur_kind(cur_kind), .ale(ale),
  .addr_mid(addr_mid), .stat_n(stat_n), .ad_oe(ad_oe), .done(done), .rdy(rdy)
);

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [19:0] req_addr = 20'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_ready, done, ad_oe, ale;
  logic [7:0]  rd_data, ad_out, addr_mid;
  logic [7:0]  ad_in = 8'h0;
  logic [3:0]  addr_hi;
  logic [2:0]  stat_n;
  logic        rdy = 1'b1;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .done(done), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_hi(addr_hi), .addr_mid(addr_mid), .ale(ale),
    .stat_n(stat_n), .rdy(rdy)
  );

  typedef struct {
    logic [2:0]  kind;
    logic [19:0] addr;
    logic [7:0]  wdata;
    int          waits;
    bit          b2b;
  } item_t;

  item_t exp_q[$];
  int    wait_q[$];
  int    issued = 0;
  int    done_seen = 0;

  function automatic logic [2:0] scode(input logic [2:0] k);
    case (k)
      3'd0: return 3'b100;
      3'd1: return 3'b101;
      3'd2: return 3'b110;
      3'd3: return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [7:0] dev_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [19:0] a, input logic [7:0] wd, input int w, input bit b2b);
    item_t it;
    it.kind = k; it.addr = a; it.wdata = wd; it.waits = w; it.b2b = b2b;
    exp_q.push_back(it);
    wait_q.push_back(w);
    issued++;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Device model: ready and read data
  int dev_ph = 0;
  int dev_w = 0;
  always @(negedge clk) begin
    if (ale) begin
      dev_w  = (wait_q.size() > 0) ? wait_q.pop_front() : 0;
      dev_ph = 0;
      ad_in  = dev_byte({addr_hi, addr_mid, ad_out});
      rdy    = 1'b1;
    end else begin
      dev_ph++;
      if (dev_ph >= 2 && dev_w > 0) begin
        rdy = 1'b0;
        dev_w--;
      end else rdy = 1'b1;
    end
  end

  // Monitor / scoreboard
  item_t      cur;
  bit         in_cyc = 0;
  int         ph = 0;
  int         since_done = 100;
  logic [7:0] mid_hold = 8'h0;
  logic [2:0] prev_stat = 3'b111;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected cycle", 1, 0);
        else begin
          cur = exp_q.pop_front();
          chk(prev_stat == scode(cur.kind), "R6 announce", prev_stat, scode(cur.kind));
          chk(stat_n == scode(cur.kind), "R5 status", stat_n, scode(cur.kind));
          chk({addr_hi, addr_mid, ad_out} == cur.addr && ad_oe, "R3 address", {addr_hi, addr_mid, ad_out}, cur.addr);
          if (cur.b2b) chk(since_done == 1, "R10 back-to-back", since_done, 1);
          mid_hold = addr_mid; ph = 0; in_cyc = 1;
        end
      end else if (in_cyc) begin
        ph++;
        chk(addr_mid == mid_hold, "R4 mid byte", addr_mid, mid_hold);
        if (ph == 1) begin
          if (cur.kind == 3'd2 || cur.kind == 3'd4)
            chk(ad_oe && ad_out == cur.wdata, "R8 write data T2", ad_out, cur.wdata);
          else
            chk(!ad_oe, "R9 float T2", ad_oe, 0);
          chk(stat_n == scode(cur.kind), "R6 status T2", stat_n, scode(cur.kind));
        end
        if (done) begin
          done_seen++;
          chk(ph == 3 + cur.waits, "R7 R2 length", ph + 1, 4 + cur.waits);
          if (cur.kind == 3'd2 || cur.kind == 3'd4)
            chk(ad_oe && ad_out == cur.wdata, "R8 write data T4", ad_out, cur.wdata);
          else
            chk(rd_data == dev_byte(cur.addr), "R9 read data", rd_data, dev_byte(cur.addr));
          in_cyc = 0; since_done = 0;
        end else if (ph >= 2) begin
          chk(stat_n == 3'b111, "R6 passive T3/Tw", stat_n, 3'b111);
        end
      end else begin
        if (done) chk(0, "R2 stray done", 1, 0);
      end
      if (!in_cyc && !ale) since_done++;
      prev_stat = stat_n;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat_n == 3'b111, "R1 status", stat_n, 3'b111);
    chk(!ale && !ad_oe && !done, "R1 outputs", {ale, ad_oe, done}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(3'd0, 20'hF0123, 8'h00, 0, 0);
    repeat (6) @(negedge clk);
    chk(stat_n == 3'b111, "R6 idle passive", stat_n, 3'b111);
    issue(3'd1, 20'h4A5B6, 8'h00, 0, 0);
    repeat (6) @(negedge clk);
    issue(3'd2, 20'h89ABC, 8'hA5, 2, 0);
    repeat (8) @(negedge clk);
    issue(3'd3, 20'h003F8, 8'h00, 1, 0);
    repeat (7) @(negedge clk);
    issue(3'd4, 20'h003F9, 8'h5A, 0, 0);
    repeat (6) @(negedge clk);

    // back-to-back burst, R10
    issue(3'd1, 20'h12345, 8'h00, 0, 0);
    issue(3'd2, 20'hFEDCB, 8'h3C, 3, 1);
    issue(3'd0, 20'hFFFF0, 8'h00, 0, 1);
    issue(3'd3, 20'h00060, 8'h00, 4, 1);
    issue(3'd4, 20'h00061, 8'hC3, 1, 1);
    issue(3'd1, 20'hB8000, 8'h00, 0, 1);

    for (int i = 0; i < 8; i++) begin
      issue(3'(i % 5), {i[3:0], 16'h1357 ^ 16'(i * 771)}, 8'(i * 29), i % 3, 0);
      repeat (i % 2) @(negedge clk);
    end

    while (in_cyc || exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(stat_n == 3'b111 && req_ready, "R6 R10 final idle", {stat_n, req_ready}, 4'hF);
    chk(done_seen == issued, "R2 done count", done_seen, issued);
    finish_run();
  end
endmodule